// File: doc/BRIEF.md
# Combining Fetch-and-Add Unit

This block lets a group of thread processors share a small set of counter registers, each processor taking a private slot from one of them atomically. Each port asks for one operation by giving an increment and choosing a counter. Every request made in the same cycle is folded into one prefix-sum pass. Each requester receives the counter value as it stood just before its own contribution. The counter ends up holding the old value plus every increment. Requests aimed at different counters in one cycle are handled side by side. Requests aimed at one counter are ranked by ascending port number.

A host port can load any counter and read it back. When the host loads a counter in the same cycle that requests target it, the load wins. Those requests are held inside the unit for one cycle and then served against the loaded value. A typical use is array compaction: every thread with work adds 1 to a counter that starts at zero, gets a distinct index, and the counter ends equal to the number of contributors.

Top module: `prefix_add_unit`

## Requirements
- R1: After reset every counter reads 0 and no done pulse is asserted.
- R2: An accepted request raises its port's done bit for exactly the cycle after the clock edge that accepts it, with the value the counter held before the request.
- R3: Requests to one counter in one cycle are ranked by ascending port index: port p receives the counter value plus the sum of the increments of lower-numbered ports targeting the same counter in that cycle.
- R4: After a cycle of accepted requests, a counter holds its previous value plus the sum of all increments applied to it in that cycle.
- R5: Requests to different counters in the same cycle are served in that cycle without affecting one another.
- R6: All sums wrap modulo 2^32.
- R7: With increment 1 on every requesting port and a counter starting at 0, the ports receive consecutive distinct indices 0..k-1 and the counter ends at k.
- R8: A host load of a counter takes effect at the next edge and overrides requests to that counter in the same cycle; those requests are held one cycle, produce no done pulse in the next cycle's output, and are then served against the loaded value.
- R9: The host read port shows the selected counter's current value combinationally, and unselected counters are unaffected by a host load.
- R10: A request with increment 0 returns the counter value and leaves the counter unchanged; a port with no request produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 8 | One request strobe per port |
| req_inc | input | 256 | Increment per port, 32 bits each, port p at bits [32p+31:32p] |
| req_sel | input | 16 | Counter select per port, 2 bits each, port p at bits [2p+1:2p] |
| rsp_done | output | 8 | One-cycle done pulse per port |
| rsp_val | output | 256 | Pre-add value per port, same packing as req_inc |
| host_we | input | 1 | Host load strobe |
| host_sel | input | 2 | Counter loaded by the host |
| host_wdata | input | 32 | Value loaded by the host |
| host_rsel | input | 2 | Counter shown on host_rdata |
| host_rdata | output | 32 | Current value of the selected counter |

## Verification
A wrong rank or carry inside the prefix network shows up as a duplicated or skipped value on rsp_val in the cycle right after the request, and as a wrong counter total on host_rdata one cycle later. A lost or doubled held request after a host collision shows as a missing or extra done pulse in the second cycle after the load. The scoreboard pairs every done pulse with the value predicted from the requirements, so any misplaced pulse is caught within one cycle.

// File: rtl/psu_pkg.sv
package psu_pkg;
  parameter int unsigned PSU_PORTS = 8;
  parameter int unsigned PSU_BASES = 4;
  parameter int unsigned PSU_DW    = 32;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/psu_hold.sv
module psu_hold #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [DW-1:0] in_inc,
  input  logic [SW-1:0] in_sel,
  input  logic          host_we,
  input  logic [SW-1:0] host_sel,
  output logic          acc,
  output logic [DW-1:0] eff_inc,
  output logic [SW-1:0] eff_sel,
  output logic          pend_q
);
  logic [DW-1:0] held_inc_q;
  logic [SW-1:0] held_sel_q;
  logic          eff_v;
  logic          blocked;
  logic          pend_d;

  always_comb begin
    eff_v   = pend_q | in_v;
    eff_inc = pend_q ? held_inc_q : in_inc;
    eff_sel = pend_q ? held_sel_q : in_sel;
    blocked = eff_v & host_we & (eff_sel == host_sel);
    acc     = eff_v & ~blocked;
    pend_d  = blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_inc_q <= '0;
      held_sel_q <= '0;
    end else if (blocked) begin
      held_inc_q <= eff_inc;
      held_sel_q <= eff_sel;
    end
  end

  // R8: a fresh request colliding with a host load is held for the next cycle
  a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && !pend_q && host_we && in_sel == host_sel) |=> pend_q);
endmodule

// File: rtl/psu_rank.sv
module psu_rank #(
  parameter int unsigned NP = 8,
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic [NP-1:0]    acc,
  input  logic [NP*DW-1:0] inc,
  input  logic [NP*SW-1:0] sel,
  input  logic [NB*DW-1:0] base,
  output logic [NP*DW-1:0] pre,
  output logic [NB*DW-1:0] tot
);
  logic [DW-1:0] run [NB];
  logic [DW-1:0] sum [NB];

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      run[b] = base[b*DW +: DW];
      sum[b] = '0;
    end
    pre = '0;
    for (int p = 0; p < NP; p++) begin
      pre[p*DW +: DW] = run[sel[p*SW +: SW]];
      if (acc[p]) begin
        run[sel[p*SW +: SW]] = run[sel[p*SW +: SW]] + inc[p*DW +: DW];
        sum[sel[p*SW +: SW]] = sum[sel[p*SW +: SW]] + inc[p*DW +: DW];
      end
    end
    for (int b = 0; b < NB; b++) tot[b*DW +: DW] = sum[b];
  end
endmodule

// File: rtl/psu_bank.sv
module psu_bank #(
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB*DW-1:0] tot,
  input  logic             host_we,
  input  logic [SW-1:0]    host_sel,
  input  logic [DW-1:0]    host_wdata,
  input  logic [SW-1:0]    host_rsel,
  output logic [NB*DW-1:0] base,
  output logic [DW-1:0]    host_rdata
);
  logic [DW-1:0] cnt_q [NB];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_cnt
      logic          hit;
      logic          en;
      logic [DW-1:0] cnt_d;
      always_comb begin
        hit   = host_we & (host_sel == SW'(b));
        en    = hit | (tot[b*DW +: DW] != '0);
        cnt_d = hit ? host_wdata : cnt_q[b] + tot[b*DW +: DW];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt_q[b] <= '0;
        else if (en) cnt_q[b] <= cnt_d;
      end
      assign base[b*DW +: DW] = cnt_q[b];
    end
  endgenerate

  always_comb host_rdata = cnt_q[host_rsel];
endmodule

// File: rtl/prefix_add_unit.sv
module prefix_add_unit
  import psu_pkg::*;
#(
  parameter int unsigned NP = PSU_PORTS,
  parameter int unsigned NB = PSU_BASES,
  parameter int unsigned DW = PSU_DW,
  localparam int unsigned SW = sel_width(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  input  logic [NP*DW-1:0] req_inc,
  input  logic [NP*SW-1:0] req_sel,
  output logic [NP-1:0]    rsp_done,
  output logic [NP*DW-1:0] rsp_val,
  input  logic             host_we,
  input  logic [SW-1:0]    host_sel,
  input  logic [DW-1:0]    host_wdata,
  input  logic [SW-1:0]    host_rsel,
  output logic [DW-1:0]    host_rdata
);
  logic [NP-1:0]    acc;
  logic [NP-1:0]    pend;
  logic [NP*DW-1:0] eff_inc;
  logic [NP*SW-1:0] eff_sel;
  logic [NP*DW-1:0] pre;
  logic [NB*DW-1:0] tot;
  logic [NB*DW-1:0] base;

  genvar p;
  generate
    for (p = 0; p < NP; p++) begin : g_port
      psu_hold #(.DW(DW), .SW(SW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_v     (req_valid[p]),
        .in_inc   (req_inc[p*DW +: DW]),
        .in_sel   (req_sel[p*SW +: SW]),
        .host_we  (host_we),
        .host_sel (host_sel),
        .acc      (acc[p]),
        .eff_inc  (eff_inc[p*DW +: DW]),
        .eff_sel  (eff_sel[p*SW +: SW]),
        .pend_q   (pend[p])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_val[p*DW +: DW] <= '0;
        else if (acc[p]) rsp_val[p*DW +: DW] <= pre[p*DW +: DW];
      end

      // R2: a done pulse only follows a request that was present
      a_r2_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done[p] |-> $past(req_valid[p] | pend[p]));

      // R8: a request colliding with a host load gives no done next cycle
      a_r8_stall_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && !pend[p] && host_we && req_sel[p*SW +: SW] == host_sel)
          |=> !rsp_done[p]);

      // R4: a lone request leaves its counter at returned value plus increment
      a_r4_single_update: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[p] && $countones(acc) == 1 && !host_we)
          |=> base[$past(eff_sel[p*SW +: SW])*DW +: DW]
              == rsp_val[p*DW +: DW] + $past(eff_inc[p*DW +: DW]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_done <= '0;
    else        rsp_done <= acc;
  end

  psu_rank #(.NP(NP), .NB(NB), .DW(DW), .SW(SW)) u_rank (
    .acc  (acc),
    .inc  (eff_inc),
    .sel  (eff_sel),
    .base (base),
    .pre  (pre),
    .tot  (tot)
  );

  psu_bank #(.NB(NB), .DW(DW), .SW(SW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .tot        (tot),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rsel  (host_rsel),
    .base       (base),
    .host_rdata (host_rdata)
  );

  // R8: a host load is visible on the read port at the next cycle
  a_r8_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_we) && host_rsel == $past(host_sel)) |-> host_rdata == $past(host_wdata));
endmodule

// File: tb/prefix_add_unit_bench.sv
module prefix_add_unit_bench;
  localparam int NP = 8;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int SW = 2;

  typedef struct {
    int          port;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [NP*DW-1:0] req_inc = '0;
  logic [NP*SW-1:0] req_sel = '0;
  logic [NP-1:0]    rsp_done;
  logic [NP*DW-1:0] rsp_val;
  logic             host_we = 1'b0;
  logic [SW-1:0]    host_sel = '0;
  logic [DW-1:0]    host_wdata = '0;
  logic [SW-1:0]    host_rsel = '0;
  logic [DW-1:0]    host_rdata;

  int errors = 0;
  int checks = 0;
  exp_t q[$];

  logic          tv [NP];
  logic [1:0]    ts [NP];
  logic [31:0]   ti [NP];
  logic [31:0]   mbase [NB];
  logic          mp_v [NP];
  logic [1:0]    mp_s [NP];
  logic [31:0]   mp_i [NP];
  string         cur_req = "R2";

  prefix_add_unit u_prefix_add_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inc(req_inc),
    .req_sel(req_sel), .rsp_done(rsp_done), .rsp_val(rsp_val),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rsel(host_rsel), .host_rdata(host_rdata)
  );

  always #10 clk = ~clk;

  task automatic clear_req();
    for (int p = 0; p < NP; p++) begin
      tv[p] = 1'b0; ts[p] = '0; ti[p] = '0;
    end
  endtask

  // drives one cycle at a negedge, predicts results, waits to the next negedge
  task automatic step(input logic hwe, input logic [1:0] hsel, input logic [31:0] hwd);
    logic nv [NP];
    logic [1:0] ns [NP];
    logic [31:0] ni [NP];
    for (int p = 0; p < NP; p++) begin
      req_valid[p]          = tv[p];
      req_sel[p*SW +: SW]   = ts[p];
      req_inc[p*DW +: DW]   = ti[p];
    end
    host_we = hwe; host_sel = hsel; host_wdata = hwd;
    for (int p = 0; p < NP; p++) begin
      logic v; logic [1:0] s; logic [31:0] i;
      v = mp_v[p] | tv[p];
      s = mp_v[p] ? mp_s[p] : ts[p];
      i = mp_v[p] ? mp_i[p] : ti[p];
      nv[p] = 1'b0; ns[p] = s; ni[p] = i;
      if (v) begin
        if (hwe && s == hsel) nv[p] = 1'b1;
        else begin
          q.push_back('{p, mbase[s], cur_req});
          mbase[s] = mbase[s] + i;
        end
      end
    end
    if (hwe) mbase[hsel] = hwd;
    for (int p = 0; p < NP; p++) begin
      mp_v[p] = nv[p]; mp_s[p] = ns[p]; mp_i[p] = ni[p];
    end
    @(negedge clk);
    req_valid = '0;
    host_we = 1'b0;
  endtask

  task automatic check_base(input int b, input string r);
    host_rsel = b[1:0];
    #1;
    checks++;
    if (host_rdata !== mbase[b]) begin
      errors++;
      $display("FAIL %s counter %0d actual=%h expected=%h", r, b, host_rdata, mbase[b]);
    end
  endtask

  // monitor: pairs every done pulse with the oldest predicted result
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (rsp_done[p]) begin
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected done port=%0d actual=%h expected=none", p, rsp_val[p*DW +: DW]);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.port != p || rsp_val[p*DW +: DW] !== e.val) begin
              errors++;
              $display("FAIL %s port actual=%0d/%h expected=%0d/%h",
                       e.req, p, rsp_val[p*DW +: DW], e.port, e.val);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) mbase[b] = '0;
    for (int p = 0; p < NP; p++) begin mp_v[p] = 1'b0; mp_s[p] = '0; mp_i[p] = '0; end
    clear_req();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (rsp_done !== '0) begin
      errors++;
      $display("FAIL R1 done actual=%b expected=0", rsp_done);
    end
    for (int b = 0; b < NB; b++) check_base(b, "R1");

    // R2: one request
    cur_req = "R2";
    clear_req(); tv[3] = 1'b1; ts[3] = 2'd1; ti[3] = 32'd5;
    step(1'b0, 2'd0, '0);
    clear_req(); step(1'b0, 2'd0, '0);
    check_base(1, "R2");

    // R7: all ports add 1 to counter 0
    cur_req = "R7";
    clear_req();
    for (int p = 0; p < NP; p++) begin tv[p] = 1'b1; ts[p] = 2'd0; ti[p] = 32'd1; end
    step(1'b0, 2'd0, '0);
    clear_req(); step(1'b0, 2'd0, '0);
    check_base(0, "R7");

    // R3 / R5: mixed counters and increments
    cur_req = "R3_R5";
    clear_req();
    for (int p = 0; p < NP; p++) begin
      tv[p] = (p != 6); ts[p] = 2'(p % 3); ti[p] = 32'(p * 11 + 3);
    end
    step(1'b0, 2'd0, '0);
    clear_req(); step(1'b0, 2'd0, '0);
    for (int b = 0; b < 3; b++) check_base(b, "R4");

    // R6: wrap across 2^32
    cur_req = "R6";
    clear_req(); step(1'b1, 2'd2, 32'hFFFF_FFF0);
    check_base(2, "R9");
    check_base(1, "R9");
    tv[0] = 1'b1; ts[0] = 2'd2; ti[0] = 32'h10;
    tv[1] = 1'b1; ts[1] = 2'd2; ti[1] = 32'h5;
    step(1'b0, 2'd0, '0);
    clear_req(); step(1'b0, 2'd0, '0);
    check_base(2, "R6");

    // R8: host load collides with two requests; a third goes elsewhere
    cur_req = "R8";
    clear_req();
    tv[2] = 1'b1; ts[2] = 2'd3; ti[2] = 32'd7;
    tv[5] = 1'b1; ts[5] = 2'd3; ti[5] = 32'd9;
    tv[1] = 1'b1; ts[1] = 2'd0; ti[1] = 32'd2;
    step(1'b1, 2'd3, 32'd100);
    checks++;
    if (rsp_done !== 8'b0000_0010) begin
      errors++;
      $display("FAIL R8 done actual=%b expected=00000010", rsp_done);
    end
    clear_req(); step(1'b0, 2'd0, '0);
    checks++;
    if (rsp_done !== 8'b0010_0100) begin
      errors++;
      $display("FAIL R8 done actual=%b expected=00100100", rsp_done);
    end
    clear_req(); step(1'b0, 2'd0, '0);
    check_base(3, "R8");
    check_base(0, "R8");

    // R10: zero increment returns value, leaves counter
    cur_req = "R10";
    clear_req(); tv[7] = 1'b1; ts[7] = 2'd1; ti[7] = 32'd0;
    step(1'b0, 2'd0, '0);
    clear_req(); step(1'b0, 2'd0, '0);
    check_base(1, "R10");
    step(1'b0, 2'd0, '0);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing done actual=%0d pending expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule